// File: doc/BRIEF.md
# Circular Return-Address Stack with Interrupt Entry

This block holds the subroutine return addresses of a small nibble-addressed processor core. It keeps eight 20-bit entries in a ring. A call pushes its return address, and a return pops the most recent one. The ring never reports an error. When more than eight addresses are pushed, the oldest is lost. When the ring is popped past empty, it hands back whatever entry the wrapped pointer lands on.

The same ring also serves interrupt entry. A request is accepted only while the interrupt enable is set. The block then holds it pending until the core signals an instruction boundary. In that boundary cycle the block pushes the core's current program counter. It also raises a next-PC override that points at the fixed vector 0x0000F and clears the enable. Software must set the enable again before another request is accepted. Sources have no priority ordering, and the block only sees a single combined request line.

Top module: `retstk_irq_top`

## Requirements
- R1: A call pushes `call_addr_i`; a later return shows the most recently pushed and not yet popped address on `ret_addr_o` during the return cycle (last in, first out, 20-bit entries).
- R2: The ring holds 8 entries and its pointer wraps modulo 8; a ninth push overwrites the oldest entry, so after pushes v0..v8 the next eight returns give v8 down to v1.
- R3: A return on an empty ring raises no flag and yields the entry at the wrapped pointer; after pushes v0..v8 and eight returns, a ninth return gives v8 again.
- R4: A call and a return in the same cycle show the old top on `ret_addr_o`, replace the top with `call_addr_i`, and leave the depth unchanged.
- R5: An accepted request is held pending and taken only in a cycle with `instr_done_i` high; in that cycle `vec_take_o` is 1 and `vec_pc_o` is 0x0000F, and in every other cycle `vec_take_o` is 0.
- R6: Taking an interrupt pushes `pc_i`, so the next return yields that program counter.
- R7: Taking an interrupt clears `ie_o`; requests made while `ie_o` is 0 are ignored, and an interrupt is taken again only after `ie_set_i` sets the enable and a new request arrives.
- R8: In a cycle where an interrupt is taken, `call_i` and `ret_i` have no effect on the ring.
- R9: Synchronous active-low reset clears the ring pointer to 0, the pending request and the enable; stored entries keep their values, so a return right after reset yields entry 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_i | input | 1 | Push `call_addr_i` this cycle |
| call_addr_i | input | 20 | Return address to push |
| ret_i | input | 1 | Pop this cycle |
| ret_addr_o | output | 20 | Current top entry, valid as the popped value when `ret_i` is high |
| irq_req_i | input | 1 | Interrupt request |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| pc_i | input | 20 | Current program counter, pushed on interrupt entry |
| ie_set_i | input | 1 | Software sets the interrupt enable |
| ie_o | output | 1 | Interrupt enable state |
| vec_take_o | output | 1 | Next-PC override is active this cycle |
| vec_pc_o | output | 20 | Override target, the interrupt vector |

## Verification
The bench pushes nine addresses and then pops ten. A ring that saturated instead of wrapping, or that flagged underflow and froze, would return the wrong tail values. A simultaneous call and return is checked for the old top and the kept depth. A design that moved the pointer would misorder every later pop. Interrupt entry is tried with the boundary withheld for several cycles, and with a call and a return raised in the take cycle. It is also tried again after the enable has auto-cleared. A design that vectored early, pushed twice or skipped the enable clear would be caught. Reset is applied with the ring partly refilled and a request pending. This exposes a pointer or a pending flag that survives reset.

// File: rtl/retstk_pkg.sv
// Shared defaults and the stack operation encoding for the return stack.
// Assumes the ring depth is a power of two so the pointer wraps naturally.
package retstk_pkg;
    localparam int unsigned ADDR_W_DEF = 20;
    localparam int unsigned DEPTH_DEF  = 8;
    localparam logic [ADDR_W_DEF-1:0] VECTOR_DEF = 20'h0000F;

    // Operation applied to the ring in one cycle.
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;
endpackage

// File: rtl/retstk_ring.sv
// Ring storage for return addresses with a single wrapping pointer.
// The pointer addresses the next free slot; the top is the slot below it.
// No overflow or underflow detection: wrapping is the intended behaviour.
// Assumes DEPTH is a power of two. Entries are not reset.
module retstk_ring
    import retstk_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [ADDR_W-1:0] top_o
);
    localparam int unsigned PW = $clog2(DEPTH);

    logic [PW-1:0]     ptr_q;
    logic [PW-1:0]     top_idx;
    logic [PW-1:0]     wr_idx;
    logic              wr_en;
    logic [ADDR_W-1:0] slot_q [DEPTH];

    // Index of the current top entry.
    assign top_idx = ptr_q - 1'b1;

    // Select the slot written this cycle: a push fills the free slot, a swap overwrites the top.
    always_comb begin
        wr_en  = (op_i == STK_PUSH) || (op_i == STK_SWAP);
        wr_idx = (op_i == STK_SWAP) ? top_idx : ptr_q;
    end

    // Pointer update: up on push, down on pop, held on swap or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            case (op_i)
                STK_PUSH: ptr_q <= ptr_q + 1'b1;
                STK_POP:  ptr_q <= ptr_q - 1'b1;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    // One write port per slot, selected by the write index.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PW'(gi))) begin
                slot_q[gi] <= wr_addr_i;
            end
        end
    end

    // Read the top entry.
    assign top_o = slot_q[top_idx];

    assert_push_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH) |=> (ptr_q == $past(ptr_q) + 1'b1));

    assert_push_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH) |=> (top_o == $past(wr_addr_i)));

    assert_pop_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_POP) |=> (ptr_q == $past(ptr_q) - 1'b1));

    assert_swap_keeps_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_SWAP) |=> ((ptr_q == $past(ptr_q)) && (top_o == $past(wr_addr_i))));
endmodule

// File: rtl/irq_seq.sv
// Interrupt entry sequencer: latches one request while enabled and holds it
// until the core reports an instruction boundary, then fires a one-cycle take.
// Taking clears the enable; software re-enables through ie_set_i.
// Assumes a single combined request line with no source priority.
module irq_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    input  logic ie_set_i,
    output logic take_o,
    output logic ie_o
);
    logic pending_q;
    logic ie_q;

    // Take happens at the boundary that follows an accepted request.
    assign take_o = pending_q && done_i;
    assign ie_o   = ie_q;

    // Pending flag: set by an enabled request, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (take_o) begin
            pending_q <= 1'b0;
        end else if (req_i && ie_q) begin
            pending_q <= 1'b1;
        end
    end

    // Enable bit: cleared on take (which wins over a set), set by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (take_o) begin
            ie_q <= 1'b0;
        end else if (ie_set_i) begin
            ie_q <= 1'b1;
        end
    end

    assert_ie_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !ie_o);

    assert_single_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_pending_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !done_i) |=> pending_q);
endmodule

// File: rtl/retstk_irq_top.sv
// Return-address stack with interrupt entry. Calls and returns from the core
// drive the ring; an interrupt take overrides them for one cycle, pushes the
// program counter and requests a jump to the fixed vector.
// Assumes the core samples vec_take_o/vec_pc_o as a next-PC override.
module retstk_irq_top
    import retstk_pkg::*;
#(
    parameter int unsigned        ADDR_W = ADDR_W_DEF,
    parameter int unsigned        DEPTH  = DEPTH_DEF,
    parameter logic [ADDR_W-1:0]  VECTOR = VECTOR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_addr_i,
    input  logic              ret_i,
    output logic [ADDR_W-1:0] ret_addr_o,
    input  logic              irq_req_i,
    input  logic              instr_done_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              ie_set_i,
    output logic              ie_o,
    output logic              vec_take_o,
    output logic [ADDR_W-1:0] vec_pc_o
);
    logic              take;
    stk_op_e           op;
    logic [ADDR_W-1:0] wr_addr;

    irq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (irq_req_i),
        .done_i   (instr_done_i),
        .ie_set_i (ie_set_i),
        .take_o   (take),
        .ie_o     (ie_o)
    );

    // Choose the ring operation; an interrupt take masks the core's call/return.
    always_comb begin
        wr_addr = call_addr_i;
        if (take) begin
            op      = STK_PUSH;
            wr_addr = pc_i;
        end else if (call_i && ret_i) begin
            op = STK_SWAP;
        end else if (call_i) begin
            op = STK_PUSH;
        end else if (ret_i) begin
            op = STK_POP;
        end else begin
            op = STK_IDLE;
        end
    end

    retstk_ring #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .wr_addr_i (wr_addr),
        .top_o     (ret_addr_o)
    );

    assign vec_take_o = take;
    assign vec_pc_o   = VECTOR;

    assert_take_pushes_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take_o |=> (ret_addr_o == $past(pc_i)));

    assert_take_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take_o |-> instr_done_i);
endmodule

// File: tb/retstk_irq_top_bench.sv
`timescale 1ns/100ps
module retstk_irq_top_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          call_i, ret_i, irq_req_i, instr_done_i, ie_set_i;
    logic [AW-1:0] call_addr_i, pc_i;
    logic [AW-1:0] ret_addr_o, vec_pc_o;
    logic          ie_o, vec_take_o;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [AW-1:0] val;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    logic [AW-1:0] mdl [8];
    logic [2:0]    mptr = '0;

    always #2.5 clk = ~clk;

    retstk_irq_top u_retstk_irq_top (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_addr_i(call_addr_i),
        .ret_i(ret_i), .ret_addr_o(ret_addr_o), .irq_req_i(irq_req_i),
        .instr_done_i(instr_done_i), .pc_i(pc_i), .ie_set_i(ie_set_i),
        .ie_o(ie_o), .vec_take_o(vec_take_o), .vec_pc_o(vec_pc_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one core cycle and update the reference stack.
    task automatic cyc(input bit c, input logic [AW-1:0] ca, input bit r, input string tag);
        @(negedge clk);
        call_i = c; call_addr_i = ca; ret_i = r;
        irq_req_i = 0; instr_done_i = 0; ie_set_i = 0;
        if (r) exp_q.push_back('{mdl[mptr - 3'd1], tag});
        if (c && r) mdl[mptr - 3'd1] = ca;
        else if (c) begin mdl[mptr] = ca; mptr = mptr + 3'd1; end
        else if (r) mptr = mptr - 3'd1;
    endtask

    task automatic idle(input bit req, input bit done, input bit ies);
        @(negedge clk);
        call_i = 0; ret_i = 0;
        irq_req_i = req; instr_done_i = done; ie_set_i = ies;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; call_i = 0; ret_i = 0; irq_req_i = 0; instr_done_i = 0; ie_set_i = 0;
        call_addr_i = '0; pc_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        mptr = '0;
    endtask

    // Monitor: compares each effective return against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n === 1'b1 && ret_i === 1'b1 && vec_take_o === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check(0, "unexpected return", {12'h0, ret_addr_o}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(ret_addr_o === e.val, e.tag, {12'h0, ret_addr_o}, {12'h0, e.val});
                end
            end
        end
    end

    initial begin
        #200000;
        check(0, "watchdog", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0;
        do_reset();
        #1;
        check(ie_o === 1'b0, "R9 enable after reset", {31'h0, ie_o}, 32'h0);
        check(vec_take_o === 1'b0, "R9 no take after reset", {31'h0, vec_take_o}, 32'h0);

        // R1: plain LIFO order
        cyc(1, 20'hA1111, 0, "");
        cyc(1, 20'hB2222, 0, "");
        cyc(1, 20'hC3333, 0, "");
        cyc(0, '0, 1, "R1 pop third");
        cyc(0, '0, 1, "R1 pop second");
        cyc(0, '0, 1, "R1 pop first");

        // R4: simultaneous call and return
        cyc(1, 20'h0AAAA, 0, "");
        cyc(1, 20'h0BBBB, 0, "");
        cyc(1, 20'h0CCCC, 1, "R4 swap returns old top");
        cyc(0, '0, 1, "R4 new value is top");
        cyc(0, '0, 1, "R4 depth unchanged");

        // R2 / R3: nine pushes, ten pops
        for (int i = 0; i < 9; i++) cyc(1, 20'h50000 + AW'(i), 0, "");
        for (int i = 0; i < 8; i++) cyc(0, '0, 1, "R2 wrapped order");
        cyc(0, '0, 1, "R3 empty pop wraps");
        cyc(0, '0, 1, "R3 second empty pop");

        // R5 / R6 / R8: interrupt entry
        cyc(1, 20'h7E7E7, 0, "");
        idle(0, 0, 1);
        idle(1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            idle(0, 0, 0);
            #1;
            check(vec_take_o === 1'b0, "R5 waits for boundary", {31'h0, vec_take_o}, 32'h0);
        end
        @(negedge clk);
        call_i = 1; call_addr_i = 20'h99999; ret_i = 1;
        irq_req_i = 0; instr_done_i = 1; ie_set_i = 0; pc_i = 20'h12345;
        mdl[mptr] = 20'h12345; mptr = mptr + 3'd1;
        #1;
        check(vec_take_o === 1'b1, "R5 take at boundary", {31'h0, vec_take_o}, 32'h1);
        check(vec_pc_o === 20'h0000F, "R5 vector", {12'h0, vec_pc_o}, 32'hF);
        idle(0, 1, 0);
        #1;
        check(vec_take_o === 1'b0, "R5 single take", {31'h0, vec_take_o}, 32'h0);
        check(ie_o === 1'b0, "R7 enable cleared", {31'h0, ie_o}, 32'h0);
        cyc(0, '0, 1, "R6 pushed pc");
        cyc(0, '0, 1, "R8 call and return ignored");

        // R7: disabled requests ignored, re-enable allows another take
        idle(1, 0, 0);
        idle(0, 1, 0);
        #1;
        check(vec_take_o === 1'b0, "R7 request while disabled", {31'h0, vec_take_o}, 32'h0);
        idle(0, 0, 1);
        #1;
        idle(1, 0, 0);
        @(negedge clk);
        call_i = 0; ret_i = 0; irq_req_i = 0; instr_done_i = 1; ie_set_i = 0; pc_i = 20'h2468A;
        mdl[mptr] = 20'h2468A; mptr = mptr + 3'd1;
        #1;
        check(vec_take_o === 1'b1, "R7 take after re-enable", {31'h0, vec_take_o}, 32'h1);
        cyc(0, '0, 1, "R7 pushed pc");

        // R9: reset clears pointer and pending request
        for (int i = 0; i < 8; i++) cyc(1, 20'hD0000 + AW'(i), 0, "");
        for (int i = 0; i < 3; i++) cyc(1, 20'hE0000 + AW'(i), 0, "");
        idle(0, 0, 1);
        idle(1, 0, 0);
        do_reset();
        idle(0, 0, 1);
        idle(0, 1, 0);
        #1;
        check(vec_take_o === 1'b0, "R9 pending cleared", {31'h0, vec_take_o}, 32'h0);
        cyc(0, '0, 1, "R9 pointer cleared");
        idle(0, 0, 0);
        idle(0, 0, 0);
        #1;
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule